// File: doc/BRIEF.md
# LED Open/Short Detection Controller

This block sits beside the digital core of a sixteen-channel serial LED sink driver. It watches the driver's control pins: the serial clock, the latch strobe and the active-low output enable. All three are sampled and edge-detected in one fast system clock domain. In normal operation the block shifts serial data into a register, copies it into a level-sensitive latch while the strobe is high, and turns on each channel whose latched bit is set while the enable is low.

A five-clock pattern on the strobe and enable pins moves the block into an open-detection mode, a short-detection mode, or back to normal. In either detection mode, each period with the enable low is one measurement. On the third serial clock of that period, the block loads one status bit per channel from the matching comparator vector into the shift register. When the enable returns high, those bits leave on the serial output, highest channel first. A third clock that comes before the settle time has passed does not capture. Instead it raises a violation flag, and the capture waits for a later clock.

Top module: `led_fault_sensor`

## Requirements
- R1: After reset the mode is normal (mode code 0), the serial output, every drive bit and the violation flag are 0, and the shift register and latch are cleared.
- R2: In normal mode, every serial-clock rise shifts the data input into bit 0 of the shift register. The serial output always shows bit CH-1, so a word sent MSB first comes out CH clocks later.
- R3: While the strobe is high outside a mode pattern, the latch takes the shift register contents. Drive bit i equals latch bit i while the enable is low, and every drive bit is 0 while the enable is high.
- R4: Mode patterns are taken over five consecutive serial-clock rises. The enable is high, low, high, high, high on those rises. A strobe of low, low, low, high, high selects short detection (code 2). Low, low, low, high, low selects open detection (code 1). Low on all five selects normal (code 0). The mode changes only on a serial-clock rise and never takes code 3.
- R5: A strobe that goes high as part of a mode pattern does not load the latch. The latch stays blocked until the strobe has returned low after the pattern.
- R6: In a detection mode, the third serial-clock rise with the enable low loads status bit i into the register, provided the settle time has passed. Bit i is 0 when channel i's flag for the active mode is set (the open flag in open mode, the short flag in short mode) and 1 otherwise.
- R7: While the enable is low in a detection mode, no serial-clock rise shifts the data input in. The register changes only at the capture.
- R8: After the enable returns high in a detection mode, the serial output first shows the status of channel CH-1. Each serial-clock rise then brings the next lower channel.
- R9: If the third rise comes less than SETTLE_CYC system clocks after the enable fell, nothing is captured and the violation flag is set. The capture then happens on the first later rise that comes after the settle time while the enable is still low. The flag clears on the next falling edge of the enable.
- R10: A low-enable period in a detection mode with fewer than three serial-clock rises leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sck_i | input | 1 | Serial clock pin |
| lat_i | input | 1 | Latch strobe pin, level sensitive |
| oe_n_i | input | 1 | Active-low output enable pin |
| sdi_i | input | 1 | Serial data input pin |
| open_flag_i | input | CH | Per-channel flag: output voltage below the open threshold |
| short_flag_i | input | CH | Per-channel flag: output voltage above the short threshold |
| sdo_o | output | 1 | Serial output, MSB of the shift register |
| drive_o | output | CH | Per-channel sink enable |
| mode_o | output | 2 | Current mode: 0 normal, 1 open detect, 2 short detect |
| timing_violation_o | output | 1 | Third clock came before the settle time |

## Verification
In one stretch of cycles, the strobe pulse of a mode pattern and the latch's normal load path are both active. The bench provokes this by leaving a known word in the latch and then running the short-detection pattern with a fresh word in the shift register. Checking the drive outputs afterwards shows that the old word survived. A second collision comes when the third serial clock and the settle check meet on the same edge. An early triple of clocks must raise the violation flag without changing the serial output, and one later clock must then capture, which is judged through the serial output and the flag.

// File: rtl/led_fault_sensor.sv
module led_fault_sensor #(
  parameter int CH         = 16,
  parameter int SETTLE_CYC = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          lat_i,
  input  logic          oe_n_i,
  input  logic          sdi_i,
  input  logic [CH-1:0] open_flag_i,
  input  logic [CH-1:0] short_flag_i,
  output logic          sdo_o,
  output logic [CH-1:0] drive_o,
  output logic [1:0]    mode_o,
  output logic          timing_violation_o
);
  localparam int TW = $clog2(SETTLE_CYC + 1);
  localparam logic [1:0] M_NORM  = 2'd0;
  localparam logic [1:0] M_OPEN  = 2'd1;
  localparam logic [1:0] M_SHORT = 2'd2;

  logic sck_s, sck_p, lat_s, oe_s, oe_p, sdi_s;
  logic [CH-1:0] sr, latch_q;
  logic [1:0]    mode_q, ecnt;
  logic [2:0]    pos;
  logic          hold_q, lat4, cap_done, viol_q;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= 1'b0; sck_p <= 1'b0; lat_s <= 1'b0;
      oe_s  <= 1'b1; oe_p  <= 1'b1; sdi_s <= 1'b0;
    end else begin
      sck_s <= sck_i; sck_p <= sck_s; lat_s <= lat_i;
      oe_s  <= oe_n_i; oe_p <= oe_s;  sdi_s <= sdi_i;
    end

  wire sck_rise = sck_s & ~sck_p;
  wire oe_fall  = ~oe_s & oe_p;
  wire det      = (mode_q != M_NORM);
  wire det_low  = det & ~oe_s;
  wire settled  = (tcnt >= TW'(SETTLE_CYC));
  wire third    = sck_rise & det_low & (ecnt == 2'd2) & ~cap_done;
  wire cap      = third & settled;
  wire early    = third & ~settled;
  wire step_ok  = (oe_s == (pos != 3'd1)) & ((pos >= 3'd3) | ~lat_s);
  wire restart  = oe_s & ~lat_s;
  wire [CH-1:0] status = (mode_q == M_OPEN) ? ~open_flag_i : ~short_flag_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos <= '0; lat4 <= 1'b0; mode_q <= M_NORM;
    end else if (sck_rise) begin
      if (step_ok) begin
        if (pos == 3'd3) lat4 <= lat_s;
        if (pos == 3'd4) begin
          pos <= '0;
          case ({lat4, lat_s})
            2'b11:   mode_q <= M_SHORT;
            2'b10:   mode_q <= M_OPEN;
            2'b00:   mode_q <= M_NORM;
            default: mode_q <= mode_q;
          endcase
        end else pos <= pos + 3'd1;
      end else pos <= restart ? 3'd1 : 3'd0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= 1'b0;
    else if (sck_rise && step_ok && pos == 3'd2) hold_q <= 1'b1;
    else if (pos < 3'd3 && !lat_s) hold_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) latch_q <= '0;
    else if (lat_s && !hold_q) latch_q <= sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '0;
    else if (cap) sr <= status;
    else if (sck_rise && !det_low) sr <= {sr[CH-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ecnt <= '0; cap_done <= 1'b0; tcnt <= '0; viol_q <= 1'b0;
    end else begin
      if (oe_s) begin
        ecnt <= '0; cap_done <= 1'b0; tcnt <= '0;
      end else begin
        if (sck_rise && det && ecnt != 2'd2) ecnt <= ecnt + 2'd1;
        if (cap) cap_done <= 1'b1;
        if (!settled) tcnt <= tcnt + TW'(1);
      end
      if (oe_fall) viol_q <= 1'b0;
      else if (early) viol_q <= 1'b1;
    end

  assign sdo_o              = sr[CH-1];
  assign drive_o            = oe_s ? '0 : latch_q;
  assign mode_o             = mode_q;
  assign timing_violation_o = viol_q;
endmodule

module led_fault_sensor_chk #(parameter int CH = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_n_i,
  input logic          sck_rise,
  input logic          oe_s,
  input logic [1:0]    mode_q,
  input logic [1:0]    ecnt,
  input logic [CH-1:0] sr,
  input logic [CH-1:0] latch_q,
  input logic          hold_q,
  input logic [CH-1:0] drive_o,
  input logic          timing_violation_o
);
  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n_i) |-> drive_o == '0); // R3
  AST_MODE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(sck_rise)); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b11); // R4
  AST_PATTERN_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> $stable(latch_q)); // R5
  AST_SIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd0 && !oe_s && sck_rise && ecnt != 2'd2) |=> $stable(sr)); // R7
  AST_EARLY_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timing_violation_o) |-> $stable(sr)); // R9
endmodule

bind led_fault_sensor led_fault_sensor_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n_i(oe_n_i), .sck_rise(sck_rise), .oe_s(oe_s),
  .mode_q(mode_q), .ecnt(ecnt), .sr(sr), .latch_q(latch_q), .hold_q(hold_q),
  .drive_o(drive_o), .timing_violation_o(timing_violation_o)
);

// File: tb/led_fault_sensor_test.sv
module led_fault_sensor_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 40;

  logic clk = 0, rst_n = 0;
  logic sck = 0, lat = 0, oe_n = 1, sdi = 0;
  logic [15:0] opn = '0, sht = '0;
  logic sdo, viol;
  logic [15:0] drive;
  logic [1:0] mode;

  led_fault_sensor #(.CH(16), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .lat_i(lat), .oe_n_i(oe_n), .sdi_i(sdi),
    .open_flag_i(opn), .short_flag_i(sht), .sdo_o(sdo), .drive_o(drive),
    .mode_o(mode), .timing_violation_o(viol));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int kind; logic [15:0] val; string req; } item_t;
  item_t sb[$];
  int vectors = 0, fails = 0;
  bit done = 0;

  initial forever begin
    item_t it;
    logic [15:0] act;
    wait (sb.size() != 0);
    it = sb.pop_front();
    case (it.kind)
      0: act = {15'b0, sdo};
      1: act = drive;
      2: act = {14'b0, mode};
      default: act = {15'b0, viol};
    endcase
    vectors++;
    if (act !== it.val) begin
      fails++;
      $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.val);
    end
  end

  task automatic expect_v(input int k, input logic [15:0] v, input string r);
    sb.push_back('{k, v, r});
  endtask

  task automatic tick(input logic d, input logic l, input logic o);
    @(negedge clk); sdi = d; lat = l; oe_n = o; sck = 0;
    repeat (2) @(negedge clk);
    sck = 1;
    repeat (3) @(negedge clk);
    sck = 0;
    @(negedge clk);
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) tick(w[i], 1'b0, 1'b1);
  endtask

  task automatic pulse_lat();
    @(negedge clk); lat = 1;
    repeat (3) @(negedge clk);
    lat = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_oe(input logic v);
    @(negedge clk); oe_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pattern(input logic l4, input logic l5);
    tick(0, 0, 1); tick(0, 0, 0); tick(0, 0, 1); tick(0, l4, 1); tick(0, l5, 1);
    @(negedge clk); lat = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] a = 16'hA5C3, b = 16'h3C96, c = 16'h0F0F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    expect_v(2, 16'd0, "R1 mode");
    expect_v(1, 16'd0, "R1 drive");
    expect_v(0, 16'd0, "R1 sdo");
    expect_v(3, 16'd0, "R1 violation");

    shift_word(a);
    pulse_lat();
    set_oe(0);
    expect_v(1, a, "R3 drive latched word");
    set_oe(1);
    expect_v(1, 16'd0, "R3 drive off with enable high");

    for (int k = 0; k < 16; k++) begin
      expect_v(0, {15'b0, a[15-k]}, "R2 serial output order");
      tick(b[15-k], 0, 1);
    end
    expect_v(0, {15'b0, b[15]}, "R2 new word at MSB");

    pattern(1, 1);
    expect_v(2, 16'd2, "R4 short mode");
    set_oe(0);
    expect_v(1, a, "R5 latch not loaded by pattern");
    set_oe(1);

    sht = 16'h0810; opn = 16'h1234;
    set_oe(0);
    repeat (SETTLE + 5) @(negedge clk);
    tick(1, 0, 0); tick(1, 0, 0);
    expect_v(0, {15'b0, b[10]}, "R7 data input ignored");
    tick(1, 0, 0);
    expect_v(0, {15'b0, ~sht[15]}, "R6 capture on third clock");
    expect_v(3, 16'd0, "R9 no violation when settled");
    tick(0, 0, 0);
    expect_v(0, {15'b0, ~sht[15]}, "R7 held after capture");
    set_oe(1);
    for (int i = 15; i >= 0; i--) begin
      expect_v(0, {15'b0, ~sht[i]}, "R8 short status readout");
      tick(0, 0, 1);
    end

    opn = 16'h0180;
    pattern(1, 0);
    expect_v(2, 16'd1, "R4 open mode");
    set_oe(0);
    tick(0, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    expect_v(3, 16'd1, "R9 early third clock flagged");
    expect_v(0, 16'd0, "R9 no early capture");
    repeat (SETTLE + 5) @(negedge clk);
    tick(0, 0, 0);
    expect_v(0, {15'b0, ~opn[15]}, "R9 deferred capture");
    expect_v(3, 16'd1, "R9 flag held");
    set_oe(1);
    for (int i = 15; i >= 0; i--) begin
      expect_v(0, {15'b0, ~opn[i]}, "R6 open status readout");
      tick(0, 0, 1);
    end

    set_oe(0);
    expect_v(3, 16'd0, "R9 flag cleared on enable fall");
    repeat (SETTLE + 5) @(negedge clk);
    tick(1, 0, 0); tick(1, 0, 0);
    set_oe(1);
    expect_v(0, 16'd0, "R10 two clocks no capture");

    pattern(0, 0);
    expect_v(2, 16'd0, "R4 back to normal");
    shift_word(c);
    pulse_lat();
    set_oe(0);
    expect_v(1, c, "R3 normal latch after detection");
    set_oe(1);

    wait (sb.size() == 0);
    #1;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule